// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator

This block sums signed active-energy increments over a programmable number of voltage half cycles. It marks the start and end of each window with zero-crossing pulses from the voltage channel. An upstream power path delivers one increment per sample period, nominally one strobe every five master clocks. A zero-crossing detector supplies a one-cycle pulse at each crossing.

Software writes a half-cycle count. The write clears the running sum and the published result and arms the block. Summing starts at the next zero crossing. It stops once that many further crossings have been counted. At that point the sum is published as a 24-bit two's complement result and a one-cycle completion pulse is raised. A fresh window with the same count opens at the same crossing, so calibration software can read one result per window with no further writes.

Each increment can be added with its sign or by its magnitude. The running sum clamps at the 24-bit limits and does not wrap.

Top module: `lcyc_energy_acc`

## Requirements
- R1: A cycle with `cfg_wr` high clears both the running sum and `result` to 0, visible on `result` in the following cycle, and restarts half-cycle counting.
- R2: After a write of a nonzero count, samples arriving before the first `zx_pulse` are ignored. The window opens at that first pulse, and a sample in the same cycle as that pulse is also ignored.
- R3: With count N, the window closes at the Nth `zx_pulse` after the opening pulse. In the cycle after that closing pulse, `result` holds the window sum and `done` is high for exactly one cycle. `done` stays low at every earlier crossing.
- R4: A sample in the same cycle as the closing pulse belongs to the closing window. A new window with the same count opens at that closing pulse without another write, starting from a sum of 0.
- R5: With `abs_mode` = 0, each increment is added as a signed two's complement value, so negative increments reduce the sum.
- R6: With `abs_mode` = 1, the magnitude of each increment is added. For example, an increment of -32768 adds +32768.
- R7: The running sum saturates at +8388607 and at -8388608 within a window and never wraps.
- R8: A count of 0 disables accumulation. `done` never rises, and `result` stays 0 regardless of samples and crossings.
- R9: After reset, `result` is 0 and `done` is 0.
- R10: Between completions and writes, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the half-cycle count |
| cfg_cnt | input | CNT_W | Half-cycle count to program, 0 disables |
| abs_mode | input | 1 | 0 = signed accumulation, 1 = magnitude accumulation |
| smp_vld | input | 1 | Increment strobe, one per sample period |
| smp_inc | input | INC_W | Signed energy increment |
| zx_pulse | input | 1 | One-cycle voltage zero-crossing pulse |
| result | output | ACC_W | Sum of the last completed window, two's complement |
| done | output | 1 | One-cycle pulse when a window completes |

## Verification
Four behaviours are checked by assertions on every cycle:
- `result` clears after any write.
- `result` changes only on a completion or a write.
- A completion pulse follows only a counted zero crossing under a nonzero count.
- No completion follows the arming phase.

The actual window sums can only be shown by the bench scenarios. These include samples ignored before arming, the sample on the closing crossing, back-to-back windows, both accumulation modes, clamping at both limits, and the disabled zero count. The bench sweeps counts 1 to 4 in both modes and compares each result against an arithmetic model.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_ARM = 2'd1,
    ST_RUN = 2'd2
  } lcyc_st_e;
endpackage

// File: rtl/lcyc_incr_cond.sv
// Converts a raw increment into the accumulation term (signed or magnitude)
module lcyc_incr_cond #(
  parameter int INC_W = 16,
  parameter int EXT_W = 25
) (
  input  logic signed [INC_W-1:0] smp_inc,
  input  logic                    abs_mode,
  output logic signed [EXT_W-1:0] term
);
  localparam int PAD_W = EXT_W - INC_W;

  logic signed [EXT_W-1:0] ext;

  always_comb begin
    ext = {{PAD_W{smp_inc[INC_W-1]}}, smp_inc};
    if (abs_mode && smp_inc[INC_W-1]) term = -ext;
    else                              term = ext;
  end
endmodule

// File: rtl/lcyc_sat_add.sv
// Adds a widened term to the running sum and clamps to the sum width
module lcyc_sat_add #(
  parameter int ACC_W = 24
) (
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic signed [ACC_W:0]   term,
  output logic signed [ACC_W-1:0] acc_out
);
  localparam logic signed [ACC_W:0] MAXV = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0] wide;

  always_comb begin
    wide = {acc_in[ACC_W-1], acc_in} + term;
    if (wide > MAXV)      acc_out = MAXV[ACC_W-1:0];
    else if (wide < MINV) acc_out = MINV[ACC_W-1:0];
    else                  acc_out = wide[ACC_W-1:0];
  end
endmodule

// File: rtl/lcyc_hc_ctrl.sv
// Half-cycle window control: arming, crossing count, window close
module lcyc_hc_ctrl
  import lcyc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             zx_pulse,
  output lcyc_st_e         st,
  output logic [CNT_W-1:0] cnt_q,
  output logic             win_close
);
  lcyc_st_e         st_q, st_d;
  logic [CNT_W-1:0] hc_q, hc_d, hc_nxt, cnt_d;

  assign hc_nxt = hc_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign st     = st_q;

  always_comb begin
    st_d      = st_q;
    hc_d      = hc_q;
    cnt_d     = cnt_q;
    win_close = 1'b0;
    if (cfg_wr) begin
      cnt_d = cfg_cnt;
      hc_d  = '0;
      st_d  = (cfg_cnt == '0) ? ST_OFF : ST_ARM;
    end else begin
      case (st_q)
        ST_ARM: begin
          if (zx_pulse) begin
            st_d = ST_RUN;
            hc_d = '0;
          end
        end
        ST_RUN: begin
          if (zx_pulse) begin
            if (hc_nxt == cnt_q) begin
              win_close = 1'b1;
              hc_d      = '0;
            end else begin
              hc_d = hc_nxt;
            end
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      hc_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      hc_q <= hc_d;
      if (cfg_wr) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc
  import lcyc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INC_W = 16,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [CNT_W-1:0]        cfg_cnt,
  input  logic                    abs_mode,
  input  logic                    smp_vld,
  input  logic signed [INC_W-1:0] smp_inc,
  input  logic                    zx_pulse,
  output logic signed [ACC_W-1:0] result,
  output logic                    done
);
  localparam int EXT_W = ACC_W + 1;

  lcyc_st_e                st;
  logic [CNT_W-1:0]        cnt_q;
  logic                    win_close;
  logic signed [EXT_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum, acc_path;
  logic signed [ACC_W-1:0] res_q, res_d;
  logic                    done_q, acc_en, res_en;

  lcyc_hc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_cnt   (cfg_cnt),
    .zx_pulse  (zx_pulse),
    .st        (st),
    .cnt_q     (cnt_q),
    .win_close (win_close)
  );

  lcyc_incr_cond #(.INC_W(INC_W), .EXT_W(EXT_W)) cond_i (
    .smp_inc  (smp_inc),
    .abs_mode (abs_mode),
    .term     (term)
  );

  lcyc_sat_add #(.ACC_W(ACC_W)) add_i (
    .acc_in  (acc_q),
    .term    (term),
    .acc_out (acc_sum)
  );

  // Next-state for the running sum and the published result
  always_comb begin
    acc_en   = (st == ST_RUN) && smp_vld && !cfg_wr;
    acc_path = acc_en ? acc_sum : acc_q;
    res_en   = cfg_wr || win_close;
    if (cfg_wr)         acc_d = '0;
    else if (win_close) acc_d = '0;
    else                acc_d = acc_path;
    res_d = cfg_wr ? '0 : acc_path;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      done_q <= win_close;
      if (res_en) res_q <= res_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/lcyc_energy_acc_chk.sv
module lcyc_energy_acc_chk
  import lcyc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_wr,
  input logic                    zx_pulse,
  input logic signed [ACC_W-1:0] result,
  input logic                    done,
  input logic [1:0]              st,
  input logic [CNT_W-1:0]        cnt_q
);
  // R1: a write clears the published result
  assert_write_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (result == '0));

  // R3: completion only follows a crossing that was not overridden by a write
  assert_done_after_zx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(zx_pulse && !cfg_wr));

  // R8: completion never occurs under a zero count
  assert_zero_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cnt_q) != '0));

  // R2: the arming phase never produces a completion
  assert_no_done_from_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARM) |=> !done);

  // R10: result holds unless a completion or a write happened
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(cfg_wr)) |-> $stable(result));
endmodule

bind lcyc_energy_acc lcyc_energy_acc_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .zx_pulse (zx_pulse),
  .result   (result),
  .done     (done),
  .st       (st),
  .cnt_q    (cnt_q)
);

// File: tb/lcyc_energy_acc_tb_top.sv
`timescale 1ns/1ps
module lcyc_energy_acc_tb_top;
  logic               clk, rst_n, cfg_wr, abs_mode, smp_vld, zx_pulse;
  logic [7:0]         cfg_cnt;
  logic signed [15:0] smp_inc;
  logic signed [23:0] result;
  logic               done;

  int n_tests = 0;
  int n_fail  = 0;
  int dcnt    = 0;
  logic               obs_done;
  logic signed [23:0] obs_res;

  lcyc_energy_acc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cnt(cfg_cnt),
    .abs_mode(abs_mode), .smp_vld(smp_vld), .smp_inc(smp_inc),
    .zx_pulse(zx_pulse), .result(result), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n && done) dcnt <= dcnt + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: sample last cycle's outputs, then apply inputs
  task automatic step(input logic wr, input logic [7:0] c, input logic z,
                      input logic s, input logic signed [15:0] v);
    @(negedge clk);
    obs_done = done;
    obs_res  = result;
    cfg_wr   = wr;
    cfg_cnt  = c;
    zx_pulse = z;
    smp_vld  = s;
    smp_inc  = v;
  endtask

  task automatic idle();
    step(1'b0, 8'd0, 1'b0, 1'b0, 16'sd0);
  endtask

  function automatic longint addsat(input longint a, input longint v, input logic m);
    longint t;
    t = a + ((m && v < 0) ? -v : v);
    if (t > 8388607)  t = 8388607;
    if (t < -8388608) t = -8388608;
    return t;
  endfunction

  // Feed one window of n half cycles while running, close it, check result
  task automatic run_window(input int n, input int seed, input logic m, input string tag);
    longint e = 0;
    int d0 = dcnt;
    logic signed [15:0] v;
    for (int hc = 0; hc < n; hc++) begin
      for (int j = 0; j < 3; j++) begin
        v = 16'(((seed * 37 + hc * 11 + j * 53) % 400) - 250);
        step(1'b0, 8'd0, 1'b0, 1'b1, v);
        e = addsat(e, v, m);
        idle(); idle(); idle(); idle();
      end
      if (hc < n - 1) begin
        step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
        idle();
        chk(obs_done == 1'b0, "R3 no early done", obs_done, 0);
      end else begin
        v = 16'(-(seed * 7 + 3));
        step(1'b0, 8'd0, 1'b1, 1'b1, v);
        e = addsat(e, v, m);
      end
    end
    idle();
    chk(obs_done == 1'b1, {tag, " done pulse"}, obs_done, 1);
    chk(obs_res == 24'(e), {tag, " window sum"}, obs_res, e);
    idle();
    chk(obs_done == 1'b0 && dcnt == d0 + 1, "R3 single done pulse", dcnt - d0, 1);
  endtask

  task automatic sat_case(input logic m, input logic signed [15:0] v, input longint e, input string tag);
    abs_mode = m;
    step(1'b1, 8'd1, 1'b0, 1'b0, 16'sd0);
    step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
    for (int i = 0; i < 300; i++) step(1'b0, 8'd0, 1'b0, 1'b1, v);
    step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
    idle();
    chk(obs_done == 1'b1 && obs_res == 24'(e), tag, obs_res, e);
  endtask

  initial begin
    cfg_wr = 0; cfg_cnt = 0; abs_mode = 0; smp_vld = 0; smp_inc = 0; zx_pulse = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(); idle();
    chk(obs_res == 0 && obs_done == 0, "R9 reset state", obs_res, 0);

    // Sweep counts 1..4 in both modes; pre-arm samples must be ignored (R2)
    for (int m = 0; m < 2; m++) begin
      for (int n = 1; n <= 4; n++) begin
        abs_mode = logic'(m);
        step(1'b1, 8'(n), 1'b0, 1'b0, 16'sd0);
        step(1'b0, 8'd0, 1'b0, 1'b1, 16'sd1000);
        idle(); idle();
        step(1'b0, 8'd0, 1'b0, 1'b1, -16'sd700);
        step(1'b0, 8'd0, 1'b1, 1'b1, 16'sd900);
        run_window(n, n + 10 * m, logic'(m), m ? "R6 R2 abs" : "R5 R2 signed");
        run_window(n, n + 10 * m + 5, logic'(m), "R4 back-to-back");
      end
    end

    // R7 saturation at both limits
    sat_case(1'b0, 16'sd32767, 8388607, "R7 positive clamp");
    sat_case(1'b0, -16'sd32768, -8388608, "R7 negative clamp");
    sat_case(1'b1, -16'sd32768, 8388607, "R7 R6 magnitude clamp");

    // R1: write clears published result and restarts window
    abs_mode = 0;
    step(1'b1, 8'd1, 1'b0, 1'b0, 16'sd0);
    step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
    step(1'b0, 8'd0, 1'b0, 1'b1, 16'sd77);
    step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
    idle();
    chk(obs_res == 77, "R1 setup result", obs_res, 77);
    step(1'b0, 8'd0, 1'b0, 1'b1, 16'sd50);
    step(1'b1, 8'd2, 1'b0, 1'b0, 16'sd0);
    idle();
    chk(obs_res == 0, "R1 write clears result", obs_res, 0);
    step(1'b0, 8'd0, 1'b1, 1'b0, 16'sd0);
    run_window(2, 3, 1'b0, "R1 fresh window");

    // R8: zero count disables
    begin
      int d0;
      step(1'b1, 8'd0, 1'b0, 1'b0, 16'sd0);
      d0 = dcnt;
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 8'd0, 1'b1, 1'b1, 16'sd400);
        idle();
      end
      idle();
      chk(dcnt == d0, "R8 no done", dcnt - d0, 0);
      chk(obs_res == 0, "R8 result stays zero", obs_res, 0);
      chk(obs_res == 0, "R10 result held", obs_res, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #700000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule